// File: doc/BRIEF.md
# PLL Clock Control and Lock-Interrupt Unit

This block is the software-facing control register of an on-chip clock synthesizer. A simple peripheral bus programs a 16-bit control word. From that word the block makes three things. It raises interrupts when either of two PLL lock indicators changes, with a per-indicator choice of which edge counts. It raises an interrupt when the reference-clock loss detector fires. It drives a PLL power-down request that follows the programmed bit only after a fixed number of bus clocks.

While the PLL is powered down, the block overrides the system clock-source select and forces the non-PLL source, so the core never loses its clock. The lock indicators and the loss detector arrive as asynchronous level inputs. Each passes through a synchronizer before edge detection. Every qualified event sets a sticky pending bit. Software reads the pending bits at a second bus address and clears them by writing 1. A single interrupt line is raised while any pending bit is set.

Top module: `clk_synth_ctl`

## Requirements
- R1: Control word (address 0) field positions: lock-1 edge select in bits 15:14, lock-0 edge select in bits 13:12, loss interrupt enable in bit 11, lock detector enable in bit 7, power-down in bit 4, prescaler source select in bit 2. All other bits read 0, and writes to them are ignored, so writing 0xFFFF reads back 0xF894.
- R2: Edge-select code per lock input: 00 = no event, 01 = event on a rising edge of the synchronized lock level, 10 = event on a falling edge, 11 = event on either edge.
- R3: The two lock inputs are handled independently. Pending bits are read at address 1 (bit 0 lock 0, bit 1 lock 1, bit 2 reference loss; other bits read 0). Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R4: When the loss enable is 1, a rising edge of the synchronized loss-detector input sets pending bit 2. When the enable is 0, it sets nothing. A loss input held high does not set the bit again after it has been cleared.
- R5: `irq` is high exactly while at least one pending bit is set.
- R6: A write that changes the power-down bit reaches `pll_pdn` on the fourth rising clock edge after the write edge, and not before.
- R7: A further write that changes the power-down bit before that delay expires restarts the delay. Only the latest value propagates.
- R8: While `pll_pdn` is 1, `clk_sel` is 01. Otherwise `clk_sel` equals `sw_clk_sel`.
- R9: `lock_det_en` mirrors the lock detector enable bit. While that bit is 0, both lock levels are taken as 0, and the resulting edges obey the edge-select codes.
- R10: `ref_presel` mirrors the prescaler source select bit.
- R11: After reset the control word reads 0x0010, the pending bits are 0, `pll_pdn` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | 1 | 0 = control word, 1 = pending bits |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| lock0_in | input | 1 | Lock indicator 0, asynchronous |
| lock1_in | input | 1 | Lock indicator 1, asynchronous |
| ref_lost_in | input | 1 | Reference-clock loss detector, asynchronous |
| sw_clk_sel | input | 2 | Software-chosen clock source select |
| lock_det_en | output | 1 | Lock detector enable |
| ref_presel | output | 1 | Prescaler reference source select |
| pll_pdn | output | 1 | Delayed PLL power-down request |
| clk_sel | output | 2 | Effective clock source select |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a four-cycle power-down delay. With a delay this short, the bench can sample the exact edge on which `pll_pdn` changes, both for a single write and for a restarted sequence. The two-stage synchronizer keeps event latency to three edges, so every edge-select code on both lock inputs can be tried in turn, including the edges caused by switching the lock detector enable.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int unsigned REG_W    = 16;
  localparam int unsigned N_EVT    = 3;
  localparam int unsigned IE1_LSB  = 14;
  localparam int unsigned IE0_LSB  = 12;
  localparam int unsigned LOSS_BIT = 11;
  localparam int unsigned LDET_BIT = 7;
  localparam int unsigned PD_BIT   = 4;
  localparam int unsigned PRE_BIT  = 2;

  localparam logic [1:0] SAFE_SRC = 2'b01;

  typedef struct packed {
    edge_sel_e ie1;
    edge_sel_e ie0;
    logic      loss_en;
    logic      ldet_en;
    logic      pd;
    logic      presel;
  } ctrl_t;

endpackage

// File: rtl/clk_synth_sync.sv
module clk_synth_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

  initial begin
    a_r2_sync_depth: assert (STAGES >= 2);
  end
endmodule

// File: rtl/clk_synth_edge.sv
module clk_synth_edge
  import clk_synth_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw_i,
  input  logic      gate_i,
  input  edge_sel_e mode_i,
  output logic      evt_o
);
  logic sync_w;
  logic level_w;
  logic prev_q;
  logic prev_d;
  logic rise_w;
  logic fall_w;

  clk_synth_sync #(.STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_i),
    .q_o  (sync_w)
  );

  assign level_w = sync_w & gate_i;
  assign rise_w  = level_w & ~prev_q;
  assign fall_w  = ~level_w & prev_q;

  always_comb prev_d = level_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: evt_o = rise_w;
      EDGE_FALL: evt_o = fall_w;
      EDGE_ANY:  evt_o = rise_w | fall_w;
      default:   evt_o = 1'b0;
    endcase
  end

  // R2: a disabled selector never produces an event
  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == EDGE_OFF) |-> !evt_o);

  // R9: two cycles with the detector gated off leave no edge to report
  a_r9_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i && $past(!gate_i)) |-> !evt_o);
endmodule

// File: rtl/clk_synth_pdelay.sv
module clk_synth_pdelay #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic req_i,
  output logic pd_o
);
  localparam int unsigned CW = (DELAY > 2) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          pd_q, pd_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    pd_d   = pd_q;
    if (load_i) begin
      cnt_d  = LOAD_VAL;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        pd_d   = req_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      pd_q   <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      pd_q   <= pd_d;
    end
  end

  assign pd_o = pd_q;

  // R6: the output moves only when an undisturbed countdown expires
  a_r6_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o != $past(pd_o)) |-> $past(busy_q && (cnt_q == '0) && !load_i));

  // R7: any change of the request restarts the full countdown
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (busy_q && (cnt_q == LOAD_VAL)));

  initial begin
    a_r6_delay_min: assert (DELAY >= 2);
  end
endmodule

// File: rtl/clk_synth_ctl.sv
module clk_synth_ctl
  import clk_synth_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PD_DELAY    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        lock0_in,
  input  logic        lock1_in,
  input  logic        ref_lost_in,
  input  logic [1:0]  sw_clk_sel,
  output logic        lock_det_en,
  output logic        ref_presel,
  output logic        pll_pdn,
  output logic [1:0]  clk_sel,
  output logic        irq
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic rst_i_n;
  assign rst_i_n = rst_sync_q;

  // bus decode
  logic wr_ctrl, wr_stat;
  assign wr_ctrl = bus_sel & bus_wr & ~bus_addr;
  assign wr_stat = bus_sel & bus_wr &  bus_addr;

  // control word
  ctrl_t ctrl_q, ctrl_d;
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.ie1     = edge_sel_e'(bus_wdata[IE1_LSB +: 2]);
      ctrl_d.ie0     = edge_sel_e'(bus_wdata[IE0_LSB +: 2]);
      ctrl_d.loss_en = bus_wdata[LOSS_BIT];
      ctrl_d.ldet_en = bus_wdata[LDET_BIT];
      ctrl_d.pd      = bus_wdata[PD_BIT];
      ctrl_d.presel  = bus_wdata[PRE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q.ie1     <= EDGE_OFF;
      ctrl_q.ie0     <= EDGE_OFF;
      ctrl_q.loss_en <= 1'b0;
      ctrl_q.ldet_en <= 1'b0;
      ctrl_q.pd      <= 1'b1;
      ctrl_q.presel  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  // event sources: two lock inputs plus the loss detector
  logic [N_EVT-1:0] evt_w;
  logic [N_EVT-1:0] raw_w;
  edge_sel_e        mode_w [N_EVT];
  logic      [N_EVT-1:0] gate_w;

  assign raw_w     = {ref_lost_in, lock1_in, lock0_in};
  assign mode_w[0] = ctrl_q.ie0;
  assign mode_w[1] = ctrl_q.ie1;
  assign mode_w[2] = ctrl_q.loss_en ? EDGE_RISE : EDGE_OFF;
  assign gate_w    = {1'b1, ctrl_q.ldet_en, ctrl_q.ldet_en};

  for (genvar g = 0; g < N_EVT; g++) begin : g_src
    clk_synth_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_i_n),
      .raw_i (raw_w[g]),
      .gate_i(gate_w[g]),
      .mode_i(mode_w[g]),
      .evt_o (evt_w[g])
    );
  end

  // sticky pending bits, write-one-to-clear, new events win
  logic [N_EVT-1:0] pend_q, pend_d, clr_w;
  assign clr_w = wr_stat ? bus_wdata[N_EVT-1:0] : '0;

  always_comb pend_d = (pend_q & ~clr_w) | evt_w;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pend_q <= '0;
    else          pend_q <= pend_d;
  end

  // power-down path
  logic pd_load;
  assign pd_load = wr_ctrl & (bus_wdata[PD_BIT] != ctrl_q.pd);

  clk_synth_pdelay #(.DELAY(PD_DELAY)) u_pdelay (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load_i(pd_load),
    .req_i (ctrl_q.pd),
    .pd_o  (pll_pdn)
  );

  // outputs
  logic [15:0] ctrl_rd;
  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[IE1_LSB +: 2]    = ctrl_q.ie1;
    ctrl_rd[IE0_LSB +: 2]    = ctrl_q.ie0;
    ctrl_rd[LOSS_BIT]        = ctrl_q.loss_en;
    ctrl_rd[LDET_BIT]        = ctrl_q.ldet_en;
    ctrl_rd[PD_BIT]          = ctrl_q.pd;
    ctrl_rd[PRE_BIT]         = ctrl_q.presel;
  end

  assign bus_rdata   = bus_addr ? {{(REG_W-N_EVT){1'b0}}, pend_q} : ctrl_rd;
  assign irq         = |pend_q;
  assign clk_sel     = pll_pdn ? SAFE_SRC : sw_clk_sel;
  assign lock_det_en = ctrl_q.ldet_en;
  assign ref_presel  = ctrl_q.presel;

  // R5: the interrupt only rises after a qualified event
  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(irq) |-> $past(|evt_w));

  // R3: a bit written with 1 and not re-hit by an event is clear next cycle
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_stat |=> ((pend_q & $past(bus_wdata[N_EVT-1:0] & ~evt_w)) == '0));
endmodule

// File: tb/clk_synth_ctl_test.sv
module clk_synth_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        lock0_in, lock1_in, ref_lost_in;
  logic [1:0]  sw_clk_sel;
  logic        lock_det_en, ref_presel, pll_pdn, irq;
  logic [1:0]  clk_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_synth_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lock0_in(lock0_in), .lock1_in(lock1_in), .ref_lost_in(ref_lost_in),
    .sw_clk_sel(sw_clk_sel), .lock_det_en(lock_det_en),
    .ref_presel(ref_presel), .pll_pdn(pll_pdn), .clk_sel(clk_sel), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // starts and ends just after a falling edge; write lands on the next rising edge
  task automatic bus_write(input logic a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] cw(input logic [1:0] ie1, input logic [1:0] ie0,
                                     input logic loss, input logic ldet,
                                     input logic pd, input logic pre);
    return {ie1, ie0, loss, 3'b000, ldet, 2'b00, pd, 1'b0, pre, 2'b00};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    bus_read(1'b0, v); check("R11 ctrl reset", v, 16'h0010);
    bus_read(1'b1, v); check("R11 pending reset", v, 16'h0000);
    check("R11 pll_pdn reset", {15'b0, pll_pdn}, 16'h1);
    check("R11 irq reset", {15'b0, irq}, 16'h0);
    check("R8 forced source at reset", {14'b0, clk_sel}, 16'h1);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    bus_write(1'b0, 16'hFFFF);
    bus_read(1'b0, v); check("R1 reserved bits ignored", v, 16'hF894);
    check("R9 lock_det_en mirrors", {15'b0, lock_det_en}, 16'h1);
    check("R10 ref_presel mirrors", {15'b0, ref_presel}, 16'h1);
    bus_write(1'b0, cw(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0));
    bus_read(1'b0, v); check("R1 fields clear", v, 16'h0010);
    check("R10 ref_presel low", {15'b0, ref_presel}, 16'h0);
    bus_read(1'b1, v); check("R3 pending unaffected", v, 16'h0000);
  endtask

  // each lock under each edge code, with the other lock's bit watched too
  task automatic t_lock_modes();
    logic [15:0] v;
    for (int li = 0; li < 2; li++) begin
      for (int m = 0; m < 4; m++) begin
        logic [1:0] mm;
        logic [15:0] bit_m;
        mm = 2'(m);
        bit_m = (li == 0) ? 16'h1 : 16'h2;
        bus_write(1'b0, (li == 0) ? cw(2'b00, mm, 1'b0, 1'b1, 1'b1, 1'b0)
                                  : cw(mm, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0));
        bus_write(1'b1, 16'h0007);
        if (li == 0) lock0_in = 1'b1; else lock1_in = 1'b1;
        idle(5);
        bus_read(1'b1, v);
        check("R2 R3 rising edge", v, (mm[0]) ? bit_m : 16'h0);
        check("R5 irq after rise", {15'b0, irq}, mm[0] ? 16'h1 : 16'h0);
        bus_write(1'b1, 16'h0007);
        if (li == 0) lock0_in = 1'b0; else lock1_in = 1'b0;
        idle(5);
        bus_read(1'b1, v);
        check("R2 R3 falling edge", v, (mm[1]) ? bit_m : 16'h0);
      end
    end
    bus_write(1'b1, 16'h0007);
    bus_read(1'b1, v); check("R3 w1c clears", v, 16'h0000);
    check("R5 irq low when clear", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_w1c_partial();
    logic [15:0] v;
    bus_write(1'b0, cw(2'b11, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0));
    lock0_in = 1'b1; lock1_in = 1'b1;
    idle(5);
    bus_read(1'b1, v); check("R3 both pending", v, 16'h0003);
    bus_write(1'b1, 16'h0001);
    bus_read(1'b1, v); check("R3 write-one clears only its bit", v, 16'h0002);
    check("R5 irq held by remaining bit", {15'b0, irq}, 16'h1);
    bus_write(1'b1, 16'h0000);
    bus_read(1'b1, v); check("R3 write-zero keeps bit", v, 16'h0002);
    bus_write(1'b1, 16'h0002);
    lock0_in = 1'b0; lock1_in = 1'b0;
    idle(5);
    bus_write(1'b1, 16'h0007);
  endtask

  task automatic t_ldet();
    logic [15:0] v;
    bus_write(1'b0, cw(2'b11, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0));
    lock0_in = 1'b1; lock1_in = 1'b1;
    idle(5);
    bus_read(1'b1, v); check("R9 gated detector hides locks", v, 16'h0000);
    bus_write(1'b0, cw(2'b11, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0));
    idle(5);
    bus_read(1'b1, v); check("R9 enabling detector makes rise", v, 16'h0003);
    bus_write(1'b1, 16'h0007);
    bus_write(1'b0, cw(2'b11, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0));
    idle(5);
    bus_read(1'b1, v); check("R9 disabling detector makes fall", v, 16'h0002);
    bus_write(1'b1, 16'h0007);
    lock0_in = 1'b0; lock1_in = 1'b0;
    idle(5);
  endtask

  task automatic t_loss();
    logic [15:0] v;
    bus_write(1'b0, cw(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0));
    ref_lost_in = 1'b1;
    idle(5);
    bus_read(1'b1, v); check("R4 loss disabled", v, 16'h0000);
    ref_lost_in = 1'b0;
    bus_write(1'b0, cw(2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0));
    idle(4);
    ref_lost_in = 1'b1;
    idle(5);
    bus_read(1'b1, v); check("R4 loss enabled sets bit 2", v, 16'h0004);
    check("R5 irq on loss", {15'b0, irq}, 16'h1);
    bus_write(1'b1, 16'h0004);
    idle(5);
    bus_read(1'b1, v); check("R4 held loss does not re-set", v, 16'h0000);
    ref_lost_in = 1'b0;
    idle(4);
  endtask

  task automatic t_pd_delay();
    bus_write(1'b0, cw(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
    idle(3);
    check("R6 still down after 3 edges", {15'b0, pll_pdn}, 16'h1);
    check("R8 forced while down", {14'b0, clk_sel}, 16'h1);
    idle(1);
    check("R6 up on 4th edge", {15'b0, pll_pdn}, 16'h0);
    check("R8 software source when up", {14'b0, clk_sel}, 16'h2);
  endtask

  task automatic t_pd_restart();
    bus_write(1'b0, cw(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0));
    bus_write(1'b0, cw(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
    bus_write(1'b0, cw(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0));
    idle(2);
    check("R7 no early change after toggles", {15'b0, pll_pdn}, 16'h0);
    idle(1);
    check("R7 restart holds 3 edges", {15'b0, pll_pdn}, 16'h0);
    idle(1);
    check("R7 latest value after restart", {15'b0, pll_pdn}, 16'h1);
    check("R8 forced again", {14'b0, clk_sel}, 16'h1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0x0000 expected 0x0001");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; lock0_in = 1'b0; lock1_in = 1'b0; ref_lost_in = 1'b0;
    sw_clk_sel = 2'b10;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_regs();
    t_lock_modes();
    t_w1c_partial();
    t_ldet();
    t_loss();
    t_pd_delay();
    t_pd_restart();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule